// File: doc/BRIEF.md
# Configurable-Interrupt General-Purpose I/O Unit

This unit drives and observes 24 general-purpose pins through a 16-bit register port. Each pin has an output latch and a direction bit, so it works as an output or as an input. An input pin can raise an interrupt. The interrupt is either level-sensed or edge-triggered, and it has a selectable polarity or fires on both edges. Per-pin status bits are combined with per-pin enables into one active-high interrupt line toward the host.

Every 24-bit per-pin register has two 16-bit halves. The low half holds pins 0 to 15 at its base address. The high half holds pins 16 to 23 in data bits 7:0, at the base address plus 0x40. Pin inputs pass through a two-stage synchroniser before they are read back or used for interrupt detection. Software clears an edge event by writing a 1 to its status bit. Writing a 0 afterwards leaves the bit alone.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0, and `irq` is low.
- R2: The output latch is at 0x00 and the direction register is at 0x02. Their high halves are at 0x40 and 0x42 and use data bits 7:0 for pins 16 to 23. `pin_out` shows the latch and `pin_oe` shows the direction bits, where 1 means output. Both take their new value on the clock edge that accepts the write.
- R3: Reading 0x00/0x40 returns, for each pin, the latched value if the pin is an output and the synchronised pin level if it is an input. A pin change appears in that read two clock edges after it is applied.
- R4: Trigger-type bit 0 (register 0x08/0x48) selects level mode. In level mode an enabled input's status bit (0x06/0x46) is 1 while the pin is at its active level: high when the polarity bit is 1, low when it is 0. A clear write does not remove it while that level persists. It drops once the level goes away.
- R5: Trigger-type bit 1 selects edge mode. With the both-edges bit at 0, polarity 1 sets status on a rising edge and polarity 0 sets it on a falling edge. The edge of the opposite direction is ignored.
- R6: A both-edges bit of 1 sets status on either edge, whatever the polarity.
- R7: An edge-mode status bit stays set after the pin returns to its previous level. Writing 1 to it clears it. Writing 0 has no effect.
- R8: `irq` is the OR of status bits ANDed with their enable bits (0x04/0x44). An edge status latches even while its enable is 0, and `irq` rises as soon as that enable is written to 1.
- R9: A pin configured as an output never sets its status bit, whatever its pin level does.
- R10: The trigger-option registers are at 0x0A, 0x0C and 0x0E and cover pins 0-7, 8-15 and 16-23. In each one, bit (pin mod 8) of data bits 7:0 is the polarity and the same bit of data bits 15:8 is the both-edges option.
- R11: A write to an address outside the map changes no state. Reading such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Register byte address |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address (combinational) |
| pin_in | input | 24 | Asynchronous pin levels |
| pin_out | output | 24 | Output latch value |
| pin_oe | output | 24 | Output enable per pin, 1 = drive |
| irq | output | 1 | Combined active-high interrupt |

## Verification
Random mixes of direction, latch and pin values check that the readback picks the latch or the synchronised pin for each bit. Random polarity words with all pins in enabled level mode check the active-level selection on every pin and both register halves at once. Directed single-pin sequences then separate the trigger kinds. Each edge kind gets the edge it must ignore and the edge it must catch. Further sequences show that the edge kinds stay sticky under a zero write but clear on a one, and that level status survives a clear. An edge arriving while the pin is disabled or set as an output shows the split between status latching, masking and the direction qualifier.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int NPORT = 24;
    localparam int HALFW = 16;
    localparam int HIW   = NPORT - HALFW;
    localparam int GRP   = 8;
    localparam int NGRP  = NPORT / GRP;
    localparam int GW    = $clog2(NGRP);
    localparam int AW    = 7;

    localparam logic [AW-1:0] A_DATA = 7'h00;
    localparam logic [AW-1:0] A_DIR  = 7'h02;
    localparam logic [AW-1:0] A_IEN  = 7'h04;
    localparam logic [AW-1:0] A_IST  = 7'h06;
    localparam logic [AW-1:0] A_TYP  = 7'h08;
    localparam logic [AW-1:0] A_OPT0 = 7'h0A;
    localparam logic [AW-1:0] HI_OFS = 7'h40;

    typedef enum logic [2:0] {R_DATA, R_DIR, R_IEN, R_IST, R_TYP, R_OPT, R_NONE} reg_sel_e;

    typedef struct packed {
        reg_sel_e        sel;
        logic            hi;
        logic [GW-1:0]   grp;
    } dec_t;

    typedef struct packed {
        logic is_in;
        logic edge_md;
        logic pol;
        logic both;
        logic en;
    } port_cfg_t;

    function automatic dec_t decode(logic [AW-1:0] a);
        dec_t d;
        logic [AW-1:0] b;
        d.sel = R_NONE;
        d.hi  = (a & HI_OFS) != '0;
        d.grp = '0;
        b     = a & ~HI_OFS;
        case (b)
            A_DATA:  d.sel = R_DATA;
            A_DIR:   d.sel = R_DIR;
            A_IEN:   d.sel = R_IEN;
            A_IST:   d.sel = R_IST;
            A_TYP:   d.sel = R_TYP;
            default: ;
        endcase
        if (!d.hi) begin
            for (int k = 0; k < NGRP; k++) begin
                if (b == A_OPT0 + AW'(2 * k)) begin
                    d.sel = R_OPT;
                    d.grp = GW'(k);
                end
            end
        end
        return d;
    endfunction

    // merge one 16-bit half into a 24-bit per-pin word
    function automatic logic [NPORT-1:0] upd_half(logic [NPORT-1:0] old,
                                                  logic [HALFW-1:0] wd, logic hi);
        logic [NPORT-1:0] r;
        r = old;
        if (hi) r[NPORT-1:HALFW] = wd[HIW-1:0];
        else    r[HALFW-1:0]     = wd;
        return r;
    endfunction

    function automatic logic [HALFW-1:0] read_half(logic [NPORT-1:0] v, logic hi);
        return hi ? HALFW'(v[NPORT-1:HALFW]) : v[HALFW-1:0];
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
    import gpio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cur,
    input  port_cfg_t cfg,
    input  logic      clr,
    output logic      stat
);
    logic prev_q, stat_q;
    logic rise, fall, edge_hit, lvl_act;

    always_comb begin
        rise     = cur & ~prev_q;
        fall     = ~cur & prev_q;
        edge_hit = cfg.both ? (rise | fall) : (cfg.pol ? rise : fall);
        lvl_act  = cfg.pol ? cur : ~cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            prev_q <= cur;
            if (cfg.edge_md)
                stat_q <= (stat_q & ~clr) | (cfg.is_in & edge_hit);
            else
                stat_q <= cfg.is_in & cfg.en & lvl_act;
        end
    end

    assign stat = stat_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [HALFW-1:0]  bus_wdata,
    output logic [HALFW-1:0]  bus_rdata,
    input  logic [NPORT-1:0]  pin_in,
    output logic [NPORT-1:0]  pin_out,
    output logic [NPORT-1:0]  pin_oe,
    output logic              irq
);
    logic [NPORT-1:0] data_q, dir_q, ien_q, typ_q, pol_q, both_q;
    logic [NPORT-1:0] sync_w, stat_w, clr_w, pin_view;
    dec_t dec;

    assign dec = decode(bus_addr);

    gpio_sync #(.W(NPORT), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(sync_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
            ien_q  <= '0;
            typ_q  <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else if (bus_we) begin
            case (dec.sel)
                R_DATA: data_q <= upd_half(data_q, bus_wdata, dec.hi);
                R_DIR:  dir_q  <= upd_half(dir_q,  bus_wdata, dec.hi);
                R_IEN:  ien_q  <= upd_half(ien_q,  bus_wdata, dec.hi);
                R_TYP:  typ_q  <= upd_half(typ_q,  bus_wdata, dec.hi);
                R_OPT: begin
                    pol_q[dec.grp*GRP +: GRP]  <= bus_wdata[GRP-1:0];
                    both_q[dec.grp*GRP +: GRP] <= bus_wdata[2*GRP-1:GRP];
                end
                default: ;
            endcase
        end
    end

    assign clr_w = (bus_we && dec.sel == R_IST) ? upd_half('0, bus_wdata, dec.hi) : '0;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_cfg_t cfg;
        assign cfg = '{is_in: ~dir_q[p], edge_md: typ_q[p], pol: pol_q[p],
                       both: both_q[p], en: ien_q[p]};
        gpio_port_irq u_cell (
            .clk(clk), .rst(rst), .cur(sync_w[p]), .cfg(cfg),
            .clr(clr_w[p]), .stat(stat_w[p])
        );
    end

    assign pin_view = (dir_q & data_q) | (~dir_q & sync_w);

    always_comb begin
        case (dec.sel)
            R_DATA:  bus_rdata = read_half(pin_view, dec.hi);
            R_DIR:   bus_rdata = read_half(dir_q, dec.hi);
            R_IEN:   bus_rdata = read_half(ien_q, dec.hi);
            R_IST:   bus_rdata = read_half(stat_w, dec.hi);
            R_TYP:   bus_rdata = read_half(typ_q, dec.hi);
            R_OPT:   bus_rdata = {both_q[dec.grp*GRP +: GRP], pol_q[dec.grp*GRP +: GRP]};
            default: bus_rdata = '0;
        endcase
    end

    assign pin_out = data_q;
    assign pin_oe  = dir_q;
    assign irq     = |(stat_w & ien_q);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             we,
    input logic [AW-1:0]    addr,
    input logic [HALFW-1:0] wdata,
    input logic             irq,
    input logic [NPORT-1:0] pin_oe,
    input logic [NPORT-1:0] pin_out,
    input logic [NPORT-1:0] stat,
    input logic [NPORT-1:0] ien
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!irq && pin_oe == '0 && pin_out == '0));

    a_r2_dir_low_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_DIR) |=> pin_oe[HALFW-1:0] == $past(wdata));

    a_r2_data_high_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == (A_DATA | HI_OFS)) |=> pin_out[NPORT-1:HALFW] == $past(wdata[HIW-1:0]));

    a_r9_output_no_new_status: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat & ~$past(stat) & $past(pin_oe)) == '0);

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> ien != '0);
endmodule

bind gpio_irq_unit gpio_irq_chk i_chk (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .irq(irq), .pin_oe(pin_oe), .pin_out(pin_out), .stat(stat_w), .ien(ien_q)
);

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/1ps
module test_gpio_irq_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [23:0] pins = '0;
    logic [23:0] pin_out, pin_oe;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    gpio_irq_unit i_gpio_irq_unit (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [23:0] exp_view(logic [23:0] dir, logic [23:0] dat, logic [23:0] pn);
        return (dir & dat) | (~dir & pn);
    endfunction

    function automatic logic [23:0] exp_level(logic [23:0] pol, logic [23:0] pn);
        return (pol & pn) | (~pol & ~pn);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        pins = '0; we = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(logic [6:0] a, logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wr24(logic [6:0] a, logic [23:0] v);
        wr(a, v[15:0]);
        wr(a | 7'h40, {8'h00, v[23:16]});
    endtask

    task automatic rd24(logic [6:0] a, output logic [23:0] v);
        logic [15:0] lo, hi;
        rd(a, lo);
        rd(a | 7'h40, hi);
        v = {hi[7:0], lo};
    endtask

    task automatic setpins(logic [23:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] r16;
        logic [23:0] r24, dir, dat, pn, pol;
        void'($urandom(32'h5EED));

        // R1 reset state
        do_reset();
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pin_out", pin_out, 0);
        chk("R1 irq", irq, 0);
        foreach (r24[i]) ;
        rd24(7'h00, r24); chk("R1 data", r24, 0);
        rd24(7'h02, r24); chk("R1 dir", r24, 0);
        rd24(7'h04, r24); chk("R1 ien", r24, 0);
        rd24(7'h06, r24); chk("R1 status", r24, 0);
        rd24(7'h08, r24); chk("R1 type", r24, 0);
        rd(7'h0A, r16); chk("R1 opt0", r16, 0);
        rd(7'h0E, r16); chk("R1 opt2", r16, 0);

        // R11 undecoded writes
        wr(7'h20, 16'hFFFF);
        wr(7'h4A, 16'hFFFF);
        wr(7'h7E, 16'hFFFF);
        chk("R11 pin_oe", pin_oe, 0);
        chk("R11 pin_out", pin_out, 0);
        rd(7'h20, r16); chk("R11 read hole", r16, 0);
        rd24(7'h04, r24); chk("R11 ien", r24, 0);
        rd(7'h0A, r16); chk("R11 opt0", r16, 0);

        // R3 sync latency: pin 4 appears after two edges
        setpins(24'h000010);
        rd(7'h00, r16); chk("R3 one edge", r16[4], 0);
        rd(7'h00, r16); chk("R3 two edges", r16[4], 1);

        // R2 / R3 random direction, latch and pin mixes
        for (int it = 0; it < 20; it++) begin
            dir = 24'($urandom); dat = 24'($urandom); pn = 24'($urandom);
            wr24(7'h02, dir);
            wr24(7'h00, dat);
            chk("R2 pin_oe", pin_oe, dir);
            chk("R2 pin_out", pin_out, dat);
            setpins(pn);
            settle();
            rd24(7'h00, r24);
            chk("R3 data view", r24, exp_view(dir, dat, pn));
        end

        // R4 / R10 random level polarity, all inputs enabled
        do_reset();
        wr24(7'h04, 24'hFFFFFF);
        for (int it = 0; it < 20; it++) begin
            pol = 24'($urandom); pn = 24'($urandom);
            wr(7'h0A, {8'h00, pol[7:0]});
            wr(7'h0C, {8'h00, pol[15:8]});
            wr(7'h0E, {8'h00, pol[23:16]});
            setpins(pn);
            settle();
            rd24(7'h06, r24);
            chk("R4 level status", r24, exp_level(pol, pn));
            chk("R8 level irq", irq, |exp_level(pol, pn));
            rd(7'h0C, r16); chk("R10 opt1 readback", r16, {8'h00, pol[15:8]});
        end

        // R4 level status survives clear while active
        do_reset();
        wr(7'h0A, 16'h0001); wr(7'h04, 16'h0001);
        setpins(24'h000001); settle();
        rd(7'h06, r16); chk("R4 level set", r16, 16'h0001);
        wr(7'h06, 16'h0001); wr(7'h06, 16'h0000);
        rd(7'h06, r16); chk("R4 clear ignored", r16, 16'h0001);
        setpins(24'h0); settle();
        rd(7'h06, r16); chk("R4 level gone", r16, 0);
        chk("R4 irq gone", irq, 0);

        // R5 / R7 rising edge on pin 3
        do_reset();
        wr(7'h0A, 16'h0008); wr(7'h08, 16'h0008); wr(7'h04, 16'h0008);
        setpins(24'h000008); settle();
        rd(7'h06, r16); chk("R5 rise", r16, 16'h0008);
        chk("R8 irq rise", irq, 1);
        setpins(24'h0); settle();
        rd(7'h06, r16); chk("R7 sticky", r16, 16'h0008);
        wr(7'h06, 16'h0000);
        rd(7'h06, r16); chk("R7 zero write", r16, 16'h0008);
        wr(7'h06, 16'h0008); wr(7'h06, 16'h0000);
        rd(7'h06, r16); chk("R7 cleared", r16, 0);
        chk("R7 irq cleared", irq, 0);

        // R5 / R10 falling edge on pin 18 (high half)
        do_reset();
        wr(7'h0E, 16'h0000); wr(7'h48, 16'h0004); wr(7'h44, 16'h0004);
        setpins(24'h040000); settle();
        rd(7'h46, r16); chk("R5 rise ignored", r16, 0);
        setpins(24'h0); settle();
        rd(7'h46, r16); chk("R5 fall", r16, 16'h0004);
        chk("R5 irq fall", irq, 1);

        // R6 both edges on pin 9
        do_reset();
        wr(7'h0C, 16'h0202); wr(7'h08, 16'h0200); wr(7'h04, 16'h0200);
        setpins(24'h000200); settle();
        rd(7'h06, r16); chk("R6 rise", r16, 16'h0200);
        wr(7'h06, 16'h0200);
        rd(7'h06, r16); chk("R7 clear both", r16, 0);
        setpins(24'h0); settle();
        rd(7'h06, r16); chk("R6 fall", r16, 16'h0200);

        // R8 latch while disabled, irq on enable
        do_reset();
        wr(7'h0A, 16'h0020); wr(7'h08, 16'h0020);
        setpins(24'h000020); settle();
        rd(7'h06, r16); chk("R8 latched", r16, 16'h0020);
        chk("R8 masked", irq, 0);
        wr(7'h04, 16'h0020);
        chk("R8 unmasked", irq, 1);

        // R9 output pin ignores edges
        do_reset();
        wr(7'h02, 16'h0080); wr(7'h08, 16'h0080);
        wr(7'h0A, 16'h8080); wr(7'h04, 16'h0080);
        setpins(24'h000080); settle();
        setpins(24'h0); settle();
        rd(7'h06, r16); chk("R9 no status", r16, 0);
        chk("R9 no irq", irq, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule